// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used page mappings and translates virtual addresses to physical addresses. A lookup presents a virtual address and an access kind. The virtual page number is compared against every stored entry at once. One cycle later the block reports one of three outcomes: a hit with the physical address, a protection fault, or a miss. On a hit the physical address is the stored physical page number joined to the untranslated page offset. The page's cacheable and write-through flags are returned with it.

Each entry holds read, write and execute permission bits. Each lookup checks its access kind against those bits. An access the page does not allow is reported as a fault, not as a hit. A miss tells an external page walker to supply the mapping through the refill port. A refill that describes a page not resident in memory is refused and leaves the contents unchanged. A flush input empties every entry in one cycle, for use on a context switch.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss, and rsp_valid and fill_reject are low.
- R2: A lookup accepted on a clock edge with lk_valid high produces its result on the next edge. At that point rsp_valid is high, and exactly one of rsp_hit, rsp_miss and rsp_fault is high.
- R3: On a hit, rsp_paddr equals the stored physical page number in the upper bits and the low OFS_W (default 12) bits of lk_vaddr unchanged in the lower bits.
- R4: On a hit, rsp_cacheable and rsp_wthru equal the flags stored with that entry.
- R5: The lk_kind encoding is 00 load, 01 store and 10 fetch. Each needs the corresponding bit of fill_perm: bit 0 readable, bit 1 writable, bit 2 executable. Kind 11 is never allowed. A matching entry that lacks the needed bit gives rsp_fault high, rsp_hit low, and rsp_paddr and the flags zero.
- R6: A lookup that matches no valid entry gives rsp_miss high, and rsp_paddr and the flags zero.
- R7: A refill with fill_resident low is not installed. It does not replace an existing entry for the same page. fill_reject is high on the following cycle.
- R8: flush invalidates every entry on the next edge. A refill presented in the same cycle as flush is dropped.
- R9: A new page goes into the lowest-numbered invalid entry. When all entries are valid, a rotating pointer picks the entry to replace. The pointer starts at entry 0 after reset and moves on by one after each such replacement.
- R10: A refill for a page number already present updates that entry in place and uses no other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 none allowed |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry; refill needed |
| rsp_fault | output | 1 | Matching entry forbids this access kind |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_cacheable | output | 1 | Page may be cached |
| rsp_wthru | output | 1 | Page uses write-through (0: write-back) |
| fill_valid | input | 1 | Refill write strobe |
| fill_vpn | input | VA_W-OFS_W | Virtual page number of refill |
| fill_ppn | input | PA_W-OFS_W | Physical page number of refill |
| fill_perm | input | 3 | Permissions {exec, write, read} |
| fill_cacheable | input | 1 | Cacheable flag for refill |
| fill_wthru | input | 1 | Write-through flag for refill |
| fill_resident | input | 1 | Page is in memory; low means refuse |
| fill_reject | output | 1 | Previous-cycle refill was refused |
| flush | input | 1 | Invalidate all entries |

## Verification
Lookup results and fill_reject are registered, so each is due exactly one edge after its request. Refills and flushes change the stored contents on the edge that samples them, and a lookup in that same cycle still sees the old contents. The bench drives every request on a falling edge. It releases the request and samples the outputs on the next falling edge. Each result is therefore read half a cycle after the edge that produced it. A lookup that checks a refill or flush is issued only after that operation's own edge has passed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_NONE  = 2'b11
   } acc_e;

   typedef struct packed {
      logic x;
      logic w;
      logic r;
      logic cach;
      logic wthru;
   } attr_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0]            vld,
   input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
   input  logic [VPN_W-1:0]              key,
   output logic                          hit,
   output logic [IDX_W-1:0]              idx
);
   logic [ENTRIES-1:0] m;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign m[g] = vld[g] && (tags[g] == key);
   end

   assign hit = |m;

   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (m[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] vld,
   input  logic               advance,
   output logic [IDX_W-1:0]   victim
);
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_nx;
   logic [IDX_W-1:0] free_idx;

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld[i]) free_idx = IDX_W'(i);
      end
   end

   assign victim = (&vld) ? ptr_q : free_idx;

   if ((1 << IDX_W) == ENTRIES) begin : g_pow2
      assign ptr_nx = ptr_q + 1'b1;
   end else begin : g_wrap
      assign ptr_nx = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (advance) ptr_q <= ptr_nx;
   end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
   import xlat_pkg::*;
(
   input  logic [1:0] kind,
   input  attr_t      attr,
   output logic       allowed
);
   always_comb begin
      unique case (acc_e'(kind))
         ACC_LOAD:  allowed = attr.r;
         ACC_STORE: allowed = attr.w;
         ACC_FETCH: allowed = attr.x;
         default:   allowed = 1'b0;
      endcase
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFS_W   = 12,
   parameter int ENTRIES = 16,
   localparam int VPN_W  = VA_W - OFS_W,
   localparam int PPN_W  = PA_W - OFS_W,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic [1:0]       lk_kind,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_fault,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_cacheable,
   output logic             rsp_wthru,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic [2:0]       fill_perm,
   input  logic             fill_cacheable,
   input  logic             fill_wthru,
   input  logic             fill_resident,
   output logic             fill_reject,
   input  logic             flush
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be at least 2");
   end
   if (OFS_W < 1 || OFS_W >= VA_W) begin : g_bad_ofs
      $error("xlat_cache: OFS_W must lie between 1 and VA_W-1");
   end
   if (PA_W <= OFS_W) begin : g_bad_pa
      $error("xlat_cache: PA_W must exceed OFS_W");
   end

   logic [ENTRIES-1:0]            vld_q;
   logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   attr_t [ENTRIES-1:0]           attr_q;

   logic             lk_hit;
   logic [IDX_W-1:0] lk_idx;
   logic             fl_hit;
   logic [IDX_W-1:0] fl_idx;
   logic [IDX_W-1:0] victim;
   logic             allowed;

   xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
      .vld (vld_q),
      .tags(vpn_q),
      .key (lk_vaddr[VA_W-1:OFS_W]),
      .hit (lk_hit),
      .idx (lk_idx)
   );

   xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fl_match (
      .vld (vld_q),
      .tags(vpn_q),
      .key (fill_vpn),
      .hit (fl_hit),
      .idx (fl_idx)
   );

   logic             fill_ok;
   logic [IDX_W-1:0] wr_idx;
   logic             advance;

   assign fill_ok = fill_valid && fill_resident && !flush;
   assign wr_idx  = fl_hit ? fl_idx : victim;
   assign advance = fill_ok && !fl_hit && (&vld_q);

   xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (vld_q),
      .advance(advance),
      .victim (victim)
   );

   attr_t hit_attr;
   assign hit_attr = attr_q[lk_idx];

   xlat_perm u_perm (
      .kind   (lk_kind),
      .attr   (hit_attr),
      .allowed(allowed)
   );

   attr_t fill_attr;
   always_comb begin
      fill_attr.x     = fill_perm[2];
      fill_attr.w     = fill_perm[1];
      fill_attr.r     = fill_perm[0];
      fill_attr.cach  = fill_cacheable;
      fill_attr.wthru = fill_wthru;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (fill_ok) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_ok) begin
         vpn_q[wr_idx]  <= fill_vpn;
         ppn_q[wr_idx]  <= fill_ppn;
         attr_q[wr_idx] <= fill_attr;
      end
   end

   logic hit_ok;
   assign hit_ok = lk_valid && lk_hit && allowed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_miss      <= 1'b0;
         rsp_fault     <= 1'b0;
         rsp_paddr     <= '0;
         rsp_cacheable <= 1'b0;
         rsp_wthru     <= 1'b0;
         fill_reject   <= 1'b0;
      end else begin
         rsp_valid     <= lk_valid;
         rsp_hit       <= hit_ok;
         rsp_miss      <= lk_valid && !lk_hit;
         rsp_fault     <= lk_valid && lk_hit && !allowed;
         rsp_paddr     <= hit_ok ? {ppn_q[lk_idx], lk_vaddr[OFS_W-1:0]} : '0;
         rsp_cacheable <= hit_ok && hit_attr.cach;
         rsp_wthru     <= hit_ok && hit_attr.wthru;
         fill_reject   <= fill_valid && !fill_resident;
      end
   end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic [1:0]      lk_kind,
   input logic            fill_valid,
   input logic            fill_resident,
   input logic            flush,
   input logic            rsp_valid,
   input logic            rsp_hit,
   input logic            rsp_miss,
   input logic            rsp_fault,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            fill_reject
);
   p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(lk_valid));

   p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

   p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

   p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> rsp_paddr == '0);

   p_kind_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(lk_kind) == 2'b11) |-> !rsp_hit);

   p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> rsp_paddr == '0);

   p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_reject == $past(fill_valid && !fill_resident));

   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush, 2) && $past(lk_valid)) |-> rsp_miss);
endmodule

bind xlat_cache xlat_cache_chk #(.PA_W(PA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_valid     (lk_valid),
   .lk_kind      (lk_kind),
   .fill_valid   (fill_valid),
   .fill_resident(fill_resident),
   .flush        (flush),
   .rsp_valid    (rsp_valid),
   .rsp_hit      (rsp_hit),
   .rsp_miss     (rsp_miss),
   .rsp_fault    (rsp_fault),
   .rsp_paddr    (rsp_paddr),
   .fill_reject  (fill_reject)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
   localparam int VA_W = 32;
   localparam int PA_W = 32;
   localparam int OFS_W = 12;
   localparam int N = 16;
   localparam int VPN_W = VA_W - OFS_W;
   localparam int PPN_W = PA_W - OFS_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_valid = 1'b0;
   logic [VA_W-1:0] lk_vaddr = '0;
   logic [1:0] lk_kind = 2'b00;
   logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_cacheable, rsp_wthru;
   logic [PA_W-1:0] rsp_paddr;
   logic fill_valid = 1'b0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PPN_W-1:0] fill_ppn = '0;
   logic [2:0] fill_perm = 3'b000;
   logic fill_cacheable = 1'b0;
   logic fill_wthru = 1'b0;
   logic fill_resident = 1'b0;
   logic fill_reject;
   logic flush = 1'b0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ENTRIES(N)) dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
      .rsp_cacheable(rsp_cacheable), .rsp_wthru(rsp_wthru),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_perm(fill_perm), .fill_cacheable(fill_cacheable),
      .fill_wthru(fill_wthru), .fill_resident(fill_resident),
      .fill_reject(fill_reject), .flush(flush)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // outcome code: 1 hit, 2 miss, 4 fault
   task automatic lookup(input logic [VA_W-1:0] va, input logic [1:0] kind,
                         input string req, input int exp_out,
                         input logic [PA_W-1:0] exp_pa,
                         input logic exp_c, input logic exp_wt);
      int out;
      @(negedge clk);
      lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind;
      @(negedge clk);
      lk_valid = 1'b0;
      out = {29'd0, rsp_fault, rsp_miss, rsp_hit};
      chk(rsp_valid == 1'b1, req, 64'(rsp_valid), 64'd1);
      chk(out == exp_out, req, 64'(out), 64'(exp_out));
      chk(rsp_paddr == exp_pa, req, 64'(rsp_paddr), 64'(exp_pa));
      chk({rsp_cacheable, rsp_wthru} == {exp_c, exp_wt}, req,
          64'({rsp_cacheable, rsp_wthru}), 64'({exp_c, exp_wt}));
   endtask

   task automatic refill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                         input logic [2:0] perm, input logic c, input logic wt,
                         input logic res, input logic with_flush);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm;
      fill_cacheable = c; fill_wthru = wt; fill_resident = res; flush = with_flush;
      @(negedge clk);
      fill_valid = 1'b0; flush = 1'b0;
      chk(fill_reject == !res, "R7 reject flag", 64'(fill_reject), 64'(!res));
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic t_reset();
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      chk(fill_reject == 1'b0, "R1 fill_reject after reset", 64'(fill_reject), 64'd0);
      lookup(32'h0000_0123, 2'b00, "R1 empty lookup", 2, '0, 0, 0);
      lookup(32'hFFFF_F000, 2'b10, "R1 empty lookup high", 2, '0, 0, 0);
   endtask

   task automatic t_hit();
      refill(20'h12345, 20'hABCDE, 3'b111, 1'b1, 1'b0, 1'b1, 1'b0);
      lookup(32'h1234_5678, 2'b00, "R3 paddr load", 1, 32'hABCD_E678, 1, 0);
      lookup(32'h1234_5FFF, 2'b01, "R3 offset max store", 1, 32'hABCD_EFFF, 1, 0);
      lookup(32'h1234_5000, 2'b10, "R4 attrs fetch", 1, 32'hABCD_E000, 1, 0);
   endtask

   task automatic t_perm();
      refill(20'h00042, 20'h00777, 3'b001, 1'b0, 1'b1, 1'b1, 1'b0);
      lookup(32'h0004_2010, 2'b00, "R4 wthru flag read-only page", 1, 32'h0077_7010, 0, 1);
      lookup(32'h0004_2010, 2'b01, "R5 store to read-only", 4, '0, 0, 0);
      lookup(32'h0004_2010, 2'b10, "R5 fetch from read-only", 4, '0, 0, 0);
      lookup(32'h0004_2010, 2'b11, "R5 kind 11", 4, '0, 0, 0);
      refill(20'h00043, 20'h00888, 3'b100, 1'b1, 1'b1, 1'b1, 1'b0);
      lookup(32'h0004_3ABC, 2'b10, "R5 fetch from exec page", 1, 32'h0088_8ABC, 1, 1);
      lookup(32'h0004_3ABC, 2'b00, "R5 load from exec page", 4, '0, 0, 0);
      refill(20'h00044, 20'h00999, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0);
      lookup(32'h0004_4004, 2'b01, "R5 store to write page", 1, 32'h0099_9004, 0, 0);
      lookup(32'h0004_4004, 2'b00, "R5 load from write-only", 4, '0, 0, 0);
   endtask

   task automatic t_miss();
      lookup(32'h7777_7123, 2'b00, "R6 unknown page", 2, '0, 0, 0);
      lookup(32'h1234_4678, 2'b00, "R6 neighbour page", 2, '0, 0, 0);
   endtask

   task automatic t_reject();
      refill(20'h55555, 20'h11111, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0);
      lookup(32'h5555_5000, 2'b00, "R7 rejected not installed", 2, '0, 0, 0);
      refill(20'h12345, 20'h22222, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0);
      lookup(32'h1234_5678, 2'b00, "R7 existing entry kept", 1, 32'hABCD_E678, 1, 0);
   endtask

   task automatic t_flush();
      do_flush();
      lookup(32'h1234_5678, 2'b00, "R8 flush clears", 2, '0, 0, 0);
      lookup(32'h0004_3ABC, 2'b10, "R8 flush clears second", 2, '0, 0, 0);
      refill(20'h66666, 20'h33333, 3'b111, 1'b0, 1'b0, 1'b1, 1'b1);
      lookup(32'h6666_6000, 2'b00, "R8 fill with flush dropped", 2, '0, 0, 0);
   endtask

   task automatic t_overwrite();
      refill(20'h00100, 20'h00001, 3'b111, 1'b0, 1'b0, 1'b1, 1'b0);
      refill(20'h00100, 20'h00002, 3'b011, 1'b1, 1'b0, 1'b1, 1'b0);
      lookup(32'h0010_0040, 2'b00, "R10 overwritten ppn", 1, 32'h0000_2040, 1, 0);
      for (int i = 0; i < N - 1; i++)
         refill(VPN_W'(20'h00200 + i), PPN_W'(20'h00500 + i), 3'b111, 1'b0, 1'b0, 1'b1, 1'b0);
      lookup(32'h0010_0040, 2'b00, "R10 no duplicate slot used", 1, 32'h0000_2040, 1, 0);
      for (int i = 0; i < N - 1; i++)
         lookup({VPN_W'(20'h00200 + i), 12'h004}, 2'b00, "R10 all others resident",
                1, {PPN_W'(20'h00500 + i), 12'h004}, 0, 0);
   endtask

   task automatic t_rr();
      refill(20'h00300, 20'h00A00, 3'b111, 1'b0, 1'b0, 1'b1, 1'b0);
      lookup(32'h0010_0000, 2'b00, "R9 entry 0 replaced first", 2, '0, 0, 0);
      lookup(32'h0030_0000, 2'b00, "R9 new page present", 1, 32'h00A0_0000, 0, 0);
      lookup(32'h0020_0000, 2'b00, "R9 entry 1 kept", 1, 32'h0050_0000, 0, 0);
      refill(20'h00301, 20'h00A01, 3'b111, 1'b0, 1'b0, 1'b1, 1'b0);
      lookup(32'h0020_0000, 2'b00, "R9 entry 1 replaced next", 2, '0, 0, 0);
      lookup(32'h0020_1000, 2'b00, "R9 entry 2 kept", 1, 32'h0050_1000, 0, 0);
      lookup(32'h0030_0000, 2'b00, "R9 earlier replacement kept", 1, 32'h00A0_0000, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hit();
      t_perm();
      t_miss();
      t_reject();
      t_flush();
      t_overwrite();
      t_rr();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule